// File: doc/BRIEF.md
# Four-Channel PWM Controller with Period Interrupts

This block generates four independent pulse-width-modulated outputs and exposes them through a 32-bit word-addressed register interface. Each channel owns a 16-bit counter that advances on a selectable tick: every clock, or one of two divided-clock enables supplied by a separate prescaler. The counter runs against a period value and compares against a duty value to shape the output. Counting is left-aligned (a sawtooth) or center-aligned (up, then down).

Software starts and stops channels and masks their interrupts through separate set and clear registers, so no read-modify-write is needed. Each completed period raises a per-channel pending flag. A read of the pending register returns the flags and acknowledges them in the same access. The single interrupt line is the OR of the pending flags that are unmasked. Duty and period writes are staged and take effect at the next period boundary, so no shortened or glitched pulse is produced.

The global configuration word at offset 0x00 is stored here and handed to the external prescaler.

Top module: `pwm_multi`

## Requirements
- R1: After reset every register reads zero, every `pwm_o` bit is low, `irq_o` is low and `presc_cfg_o` is zero.
- R2: A write to 0x04 sets and a write to 0x08 clears the run bit of channel n for every 1 in bit n. Zero bits leave the bit unchanged. 0x0C reads the run bits, and bits 31:4 read zero.
- R3: A write to 0x10 sets and a write to 0x14 clears mask bit n for every 1 in bit n. 0x18 reads the mask, and a write to 0x18 has no effect.
- R4: A read of 0x1C returns the pending flags and clears them all. A flag raised in the same cycle as that read stays pending.
- R5: `irq_o` is high exactly while some pending flag has its mask bit set.
- R6: Channel n's window starts at 0x200 + n*0x20. It holds mode at +0x00, duty at +0x04, period at +0x08 and counter at +0x0C. Mode keeps bits 9, 8 and 3:0 and reads zero elsewhere. Duty and period keep 16 bits. The counter ignores writes. Addresses of channels that do not exist read zero.
- R7: In left-aligned mode (mode bit 8 = 0), a running channel counts 0..P-1 on its ticks and wraps to 0. The wrap tick ends a period and sets the channel's pending flag. With P = 0, every tick ends a period.
- R8: In center-aligned mode (mode bit 8 = 1), the counter rises from 0 to P and falls back to 0. The tick that returns it to 0 ends the period, so a period lasts 2P ticks (one tick for P = 0).
- R9: A running channel drives its output high while the counter is below the active duty. Mode bit 9 inverts the output. A stopped channel holds its counter at 0 and its output at the idle level: low, or high when inverted.
- R10: While a channel runs, duty and period writes reach the compare logic only at the end of the current period. While it is stopped, they apply at once.
- R11: Mode bits 3:0 select the tick: 0 every clock, 1 `tick_a_i`, 2 `tick_b_i`. Any other code halts counting.
- R12: Offset 0x00 is a 32-bit read/write word that drives `presc_cfg_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| tick_a_i | input | 1 | Divided-clock tick A from the prescaler |
| tick_b_i | input | 1 | Divided-clock tick B from the prescaler |
| presc_cfg_o | output | 32 | Global configuration word for the prescaler |
| pwm_o | output | 4 | PWM outputs, one per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets an acknowledge read that lands in the same cycle as a period end. A design that cleared first and then ignored the new flag would lose one interrupt. It also drives period 0 and period 1 in both counting modes. Here an off-by-one in the wrap compare would stretch or shorten every pulse train, and a counter that underflows in center mode would run off to 0xFFFF. Duty and period are rewritten in mid-period, so a design that applies them at once shows a cut-short pulse in the output trace. Writes of all-ones to the set, clear, mask and mode registers expose bits that should be read-only or absent.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [3:0] {
    TICK_FULL = 4'd0,
    TICK_A    = 4'd1,
    TICK_B    = 4'd2
  } tick_sel_e;

  typedef struct packed {
    logic      inv;
    logic      center;
    tick_sel_e tsel;
  } ch_mode_t;

  // global word offsets (addr[4:2])
  localparam logic [2:0] G_CFG  = 3'd0;
  localparam logic [2:0] G_RUN  = 3'd1;
  localparam logic [2:0] G_STOP = 3'd2;
  localparam logic [2:0] G_STAT = 3'd3;
  localparam logic [2:0] G_MSET = 3'd4;
  localparam logic [2:0] G_MCLR = 3'd5;
  localparam logic [2:0] G_MASK = 3'd6;
  localparam logic [2:0] G_PEND = 3'd7;

  // channel word offsets (addr[4:2])
  localparam logic [2:0] C_MODE = 3'd0;
  localparam logic [2:0] C_DUTY = 3'd1;
  localparam logic [2:0] C_PRD  = 3'd2;
  localparam logic [2:0] C_CNT  = 3'd3;
endpackage

// File: rtl/pwm_glob.sv
module pwm_glob #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_set_i,
  input  logic           run_clr_i,
  input  logic           msk_set_i,
  input  logic           msk_clr_i,
  input  logic [NCH-1:0] bits_i,
  input  logic           ack_i,
  input  logic [NCH-1:0] evt_i,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] pend_o,
  output logic           irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= '0;
      mask_o <= '0;
      pend_o <= '0;
    end else begin
      if (run_set_i) run_o <= run_o | bits_i;
      else if (run_clr_i) run_o <= run_o & ~bits_i;
      if (msk_set_i) mask_o <= mask_o | bits_i;
      else if (msk_clr_i) mask_o <= mask_o & ~bits_i;
      // new events win over the acknowledge
      pend_o <= (ack_i ? '0 : pend_o) | evt_i;
    end
  end

  assign irq_o = |(pend_o & mask_o);

  AST_RUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_set_i |=> ((run_o & $past(bits_i)) == $past(bits_i))); // R2
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_set_i && !run_clr_i) |=> $stable(run_o)); // R2
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_clr_i |=> ((mask_o & $past(bits_i)) == '0)); // R3
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (pend_o == $past(evt_i))); // R4
  AST_EVT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R4
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_a_i,
  input  logic             tick_b_i,
  input  logic             mode_wr_i,
  input  logic             duty_wr_i,
  input  logic             prd_wr_i,
  input  logic [31:0]      wdata_i,
  output ch_mode_t         mode_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0] prd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             end_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] duty_act, prd_act, cnt_n;
  logic             dir_q, dir_n, tick, wrap;
  logic [CNT_W:0]   cnt_p1;

  always_comb begin
    unique case (mode_o.tsel)
      TICK_FULL: tick = 1'b1;
      TICK_A:    tick = tick_a_i;
      TICK_B:    tick = tick_b_i;
      default:   tick = 1'b0;
    endcase
  end

  assign cnt_p1 = {1'b0, cnt_o} + 1'b1;

  always_comb begin
    wrap  = 1'b0;
    cnt_n = cnt_o;
    dir_n = dir_q;
    if (!mode_o.center) begin
      if (cnt_p1 >= {1'b0, prd_act}) wrap = 1'b1;
      else cnt_n = cnt_p1[CNT_W-1:0];
    end else if (dir_q || cnt_o >= prd_act) begin
      if (cnt_o <= CNT_W'(1)) wrap = 1'b1;
      else begin
        cnt_n = cnt_o - 1'b1;
        dir_n = 1'b1;
      end
    end else begin
      cnt_n = cnt_p1[CNT_W-1:0];
    end
  end

  assign end_o = run_i & tick & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '{inv: 1'b0, center: 1'b0, tsel: TICK_FULL};
      duty_o <= '0;
      prd_o  <= '0;
    end else begin
      if (mode_wr_i) begin
        mode_o.inv    <= wdata_i[9];
        mode_o.center <= wdata_i[8];
        mode_o.tsel   <= tick_sel_e'(wdata_i[3:0]);
      end
      if (duty_wr_i) duty_o <= wdata_i[CNT_W-1:0];
      if (prd_wr_i)  prd_o  <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      dir_q    <= 1'b0;
      duty_act <= '0;
      prd_act  <= '0;
    end else if (!run_i || (tick && wrap)) begin
      cnt_o    <= '0;
      dir_q    <= 1'b0;
      duty_act <= duty_o;
      prd_act  <= prd_o;
    end else if (tick) begin
      cnt_o <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign pwm_o = run_i ? ((cnt_o < duty_act) ^ mode_o.inv) : mode_o.inv;

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_o <= prd_act)); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !end_o) |=> ($stable(prd_act) && $stable(duty_act))); // R10
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_a_i,
  input  logic              tick_b_i,
  output logic [31:0]       presc_cfg_o,
  output logic [NCH-1:0]    pwm_o,
  output logic              irq_o
);
  localparam int unsigned HI_W = ADDR_W - 9;

  logic [2:0]     off, ch_idx;
  logic           glb_hit, win_hit, wr, rd;
  logic [NCH-1:0] run, mask, pend, evt, ch_sel;
  ch_mode_t         ch_mode [NCH];
  logic [CNT_W-1:0] ch_duty [NCH];
  logic [CNT_W-1:0] ch_prd  [NCH];
  logic [CNT_W-1:0] ch_cnt  [NCH];

  assign off     = addr_i[4:2];
  assign ch_idx  = addr_i[7:5];
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign glb_hit = (addr_i[ADDR_W-1:5] == '0) && (addr_i[1:0] == 2'b00);
  assign win_hit = (addr_i[ADDR_W-1:9] == HI_W'(1)) && !addr_i[8] && (addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) presc_cfg_o <= '0;
    else if (wr && glb_hit && off == G_CFG) presc_cfg_o <= wdata_i;
  end

  pwm_glob #(.NCH(NCH)) i_glob (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_set_i (wr && glb_hit && off == G_RUN),
    .run_clr_i (wr && glb_hit && off == G_STOP),
    .msk_set_i (wr && glb_hit && off == G_MSET),
    .msk_clr_i (wr && glb_hit && off == G_MCLR),
    .bits_i    (wdata_i[NCH-1:0]),
    .ack_i     (rd && glb_hit && off == G_PEND),
    .evt_i     (evt),
    .run_o     (run),
    .mask_o    (mask),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_sel[g] = win_hit && (ch_idx == 3'(g));
    pwm_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run[g]),
      .tick_a_i  (tick_a_i),
      .tick_b_i  (tick_b_i),
      .mode_wr_i (wr && ch_sel[g] && off == C_MODE),
      .duty_wr_i (wr && ch_sel[g] && off == C_DUTY),
      .prd_wr_i  (wr && ch_sel[g] && off == C_PRD),
      .wdata_i   (wdata_i),
      .mode_o    (ch_mode[g]),
      .duty_o    (ch_duty[g]),
      .prd_o     (ch_prd[g]),
      .cnt_o     (ch_cnt[g]),
      .end_o     (evt[g]),
      .pwm_o     (pwm_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (glb_hit) begin
      unique case (off)
        G_CFG:   rdata_o = presc_cfg_o;
        G_STAT:  rdata_o = 32'(run);
        G_MASK:  rdata_o = 32'(mask);
        G_PEND:  rdata_o = 32'(pend);
        default: rdata_o = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel[i]) begin
        unique case (off)
          C_MODE:  rdata_o = {22'd0, ch_mode[i].inv, ch_mode[i].center, 4'd0, ch_mode[i].tsel};
          C_DUTY:  rdata_o = 32'(ch_duty[i]);
          C_PRD:   rdata_o = 32'(ch_prd[i]);
          C_CNT:   rdata_o = 32'(ch_cnt[i]);
          default: rdata_o = '0;
        endcase
      end
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o); // R5
  AST_PEND_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && glb_hit && off == G_PEND) |-> (rdata_o[31:NCH] == '0)); // R4
endmodule

// File: tb/test_pwm_multi.sv
module test_pwm_multi;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = 12;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, ta = 1'b0, tb = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata, presc;
  wire  [NCH-1:0] pwm;
  wire  irq;
  bit   running = 0, rnd_ticks = 0;
  int   n_chk = 0, n_err = 0;

  logic [NCH-1:0] m_en, m_mask, m_pend;
  logic [31:0]    m_cfg;
  logic           m_inv [NCH], m_ctr [NCH], m_dir [NCH];
  logic [3:0]     m_ts  [NCH];
  logic [CW-1:0]  m_dq [NCH], m_pq [NCH], m_da [NCH], m_pa [NCH], m_cnt [NCH];

  pwm_multi i_pwm_multi (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_a_i(ta), .tick_b_i(tb),
    .presc_cfg_o(presc), .pwm_o(pwm), .irq_o(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_pwm(int c);
    if (!m_en[c]) return m_inv[c];
    return (m_cnt[c] < m_da[c]) ^ m_inv[c];
  endfunction

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    int c;
    if (a[1:0] != 0) return 0;
    case (a)
      12'h000: return m_cfg;
      12'h00C: return 32'(m_en);
      12'h018: return 32'(m_mask);
      12'h01C: return 32'(m_pend);
      default: ;
    endcase
    if (a >= 12'h200 && a < 12'h200 + NCH*32) begin
      c = int'(a - 12'h200) / 32;
      case (a & 12'h01F)
        12'h000: return {22'd0, m_inv[c], m_ctr[c], 4'd0, m_ts[c]};
        12'h004: return 32'(m_dq[c]);
        12'h008: return 32'(m_pq[c]);
        12'h00C: return 32'(m_cnt[c]);
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  task automatic model_reset();
    m_en = '0; m_mask = '0; m_pend = '0; m_cfg = '0;
    for (int c = 0; c < NCH; c++) begin
      m_inv[c] = 0; m_ctr[c] = 0; m_dir[c] = 0; m_ts[c] = 0;
      m_dq[c] = 0; m_pq[c] = 0; m_da[c] = 0; m_pa[c] = 0; m_cnt[c] = 0;
    end
  endtask

  task automatic model_step();
    logic [NCH-1:0] ends = '0;
    int c;
    for (int k = 0; k < NCH; k++) begin
      logic tk, wr_end;
      tk = (m_ts[k] == 0) ? 1'b1 : (m_ts[k] == 1) ? ta : (m_ts[k] == 2) ? tb : 1'b0;
      wr_end = 0;
      if (!m_en[k]) begin
        m_cnt[k] = 0; m_dir[k] = 0; m_da[k] = m_dq[k]; m_pa[k] = m_pq[k];
      end else if (tk) begin
        if (!m_ctr[k]) begin
          if (int'(m_cnt[k]) + 1 >= int'(m_pa[k])) wr_end = 1;
          else m_cnt[k] = m_cnt[k] + 1;
        end else if (m_dir[k] || m_cnt[k] >= m_pa[k]) begin
          if (m_cnt[k] <= 1) wr_end = 1;
          else begin m_cnt[k] = m_cnt[k] - 1; m_dir[k] = 1; end
        end else m_cnt[k] = m_cnt[k] + 1;
        if (wr_end) begin
          m_cnt[k] = 0; m_dir[k] = 0; m_da[k] = m_dq[k]; m_pa[k] = m_pq[k]; ends[k] = 1;
        end
      end
    end
    m_pend = ((req && !we && addr == 12'h01C) ? '0 : m_pend) | ends;
    if (req && we) begin
      case (addr)
        12'h000: m_cfg = wdata;
        12'h004: m_en = m_en | wdata[NCH-1:0];
        12'h008: m_en = m_en & ~wdata[NCH-1:0];
        12'h010: m_mask = m_mask | wdata[NCH-1:0];
        12'h014: m_mask = m_mask & ~wdata[NCH-1:0];
        default: ;
      endcase
      if (addr >= 12'h200 && addr < 12'h200 + NCH*32) begin
        c = int'(addr - 12'h200) / 32;
        case (addr & 12'h01F)
          12'h000: begin m_inv[c] = wdata[9]; m_ctr[c] = wdata[8]; m_ts[c] = wdata[3:0]; end
          12'h004: m_dq[c] = wdata[CW-1:0];
          12'h008: m_pq[c] = wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < NCH; c++)
        chk($sformatf("R7/R8/R9/R10 pwm_o[%0d]", c), 32'(pwm[c]), 32'(exp_pwm(c)));
      chk("R5 irq_o", 32'(irq), 32'(|(m_pend & m_mask)));
    end
    if (rnd_ticks) begin
      ta = 1'($urandom_range(0, 1));
      tb = 1'($urandom_range(0, 3) == 0);
    end
  end

  task automatic wr_reg(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_const(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 chk(tag, rdata, exp);
    @(negedge clk); req = 0;
  endtask

  task automatic rd_model(logic [AW-1:0] a, string tag);
    logic [31:0] e;
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 e = model_read(a);
    chk(tag, rdata, e);
    @(negedge clk); req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;

    // reset state
    rd_const(12'h000, 0, "R1 cfg");
    rd_const(12'h00C, 0, "R1 run status");
    rd_const(12'h018, 0, "R1 mask");
    rd_const(12'h01C, 0, "R1 pending");
    rd_const(12'h208, 0, "R1 ch0 period");
    chk("R1 pwm_o", 32'(pwm), 0);
    chk("R1 irq_o", 32'(irq), 0);
    chk("R1 presc_cfg_o", presc, 0);

    // prescaler word
    wr_reg(12'h000, 32'hA5A5_1234);
    rd_const(12'h000, 32'hA5A5_1234, "R12 cfg readback");
    chk("R12 presc_cfg_o", presc, 32'hA5A5_1234);

    // run set/clear with channel timing all idle (tick code 15)
    for (int c = 0; c < NCH; c++) wr_reg(12'(12'h200 + c*32), 32'hF);
    wr_reg(12'h004, 32'hFFFF_FFF5);
    rd_const(12'h00C, 32'h5, "R2 set bits, upper zero");
    wr_reg(12'h008, 32'h4);
    rd_const(12'h00C, 32'h1, "R2 clear bit 2");
    wr_reg(12'h004, 32'h0);
    rd_const(12'h00C, 32'h1, "R2 zero write no effect");
    rd_const(12'h20C, 0, "R11 halted tick code keeps counter");
    wr_reg(12'h008, 32'hF);

    // mask set/clear
    wr_reg(12'h010, 32'hB);
    rd_const(12'h018, 32'hB, "R3 mask set");
    wr_reg(12'h014, 32'h2);
    rd_const(12'h018, 32'h9, "R3 mask clear");
    wr_reg(12'h018, 32'hF);
    rd_const(12'h018, 32'h9, "R3 mask read-only");
    wr_reg(12'h014, 32'hF);

    // channel window
    wr_reg(12'h240, 32'hFFFF_FFFF);
    rd_const(12'h240, 32'h30F, "R6 mode field bits");
    chk("R9 inverted idle high", 32'(pwm), 32'h4);
    wr_reg(12'h244, 32'h0001_2345);
    rd_const(12'h244, 32'h2345, "R6 duty width");
    wr_reg(12'h248, 32'hBEEF);
    rd_const(12'h248, 32'hBEEF, "R6 period");
    wr_reg(12'h24C, 32'h77);
    rd_const(12'h24C, 0, "R6 counter read-only");
    rd_const(12'h280, 0, "R6 absent channel reads zero");
    for (int c = 0; c < NCH; c++) wr_reg(12'(12'h200 + c*32), 32'h0);

    // left-aligned ch0: duty 3 period 5
    wr_reg(12'h204, 3);
    wr_reg(12'h208, 5);
    wr_reg(12'h010, 1);
    wr_reg(12'h004, 1);
    idle(3);
    rd_model(12'h20C, "R7 counter");
    idle(7);
    rd_model(12'h01C, "R4 pending after periods");
    rd_model(12'h20C, "R7 counter later");

    // period 0: event every tick, read coincides with a new flag
    wr_reg(12'h208, 0);
    idle(8);
    rd_const(12'h01C, 32'h1, "R4 pending read");
    rd_const(12'h01C, 32'h1, "R4 same-cycle flag survives ack");
    chk("R5 irq with unmasked flag", 32'(irq), 1);
    wr_reg(12'h008, 1);
    wr_reg(12'h014, 1);
    rd_const(12'h01C, 32'h1, "R4 last flag pending");
    rd_const(12'h01C, 32'h0, "R4 cleared after ack");

    // center-aligned ch1: duty 2 period 3, inverted
    wr_reg(12'h220, 32'h300);
    wr_reg(12'h224, 2);
    wr_reg(12'h228, 3);
    wr_reg(12'h004, 2);
    idle(4);
    rd_model(12'h22C, "R8 counter falling");
    idle(9);
    rd_model(12'h01C, "R8 period events");
    wr_reg(12'h228, 1);
    idle(10);
    rd_model(12'h22C, "R8 period one");
    wr_reg(12'h008, 2);

    // tick A on ch3
    wr_reg(12'h260, 32'h1);
    wr_reg(12'h264, 2);
    wr_reg(12'h268, 4);
    wr_reg(12'h004, 8);
    idle(6);
    rd_const(12'h26C, 0, "R11 no tick A no count");
    rnd_ticks = 1;
    idle(20);
    rd_model(12'h26C, "R11 tick A counting");
    wr_reg(12'h260, 32'h2);
    idle(20);
    rd_model(12'h26C, "R11 tick B counting");
    rnd_ticks = 0;
    @(negedge clk); ta = 0; tb = 0;
    wr_reg(12'h008, 8);

    // shadowed rewrite mid-period on ch0
    wr_reg(12'h200, 0);
    wr_reg(12'h204, 5);
    wr_reg(12'h208, 10);
    wr_reg(12'h004, 1);
    idle(2);
    wr_reg(12'h204, 9);
    wr_reg(12'h208, 4);
    rd_model(12'h20C, "R10 counter keeps old period");
    idle(12);
    rd_model(12'h20C, "R10 new period applied");
    wr_reg(12'h008, 1);

    // random mix
    rnd_ticks = 1;
    for (int i = 0; i < 700; i++) begin
      int op, c;
      op = $urandom_range(0, 9);
      c  = $urandom_range(0, NCH - 1);
      case (op)
        0: wr_reg(12'(12'h200 + c*32), {22'd0, 1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                                        4'd0, 4'($urandom_range(0,3))});
        1: wr_reg(12'(12'h204 + c*32), $urandom_range(0, 14));
        2: wr_reg(12'(12'h208 + c*32), $urandom_range(0, 12));
        3: wr_reg(12'h004, $urandom_range(0, 15));
        4: wr_reg(12'h008, $urandom_range(0, 15));
        5: wr_reg(12'h010, $urandom_range(0, 15));
        6: wr_reg(12'h014, $urandom_range(0, 15));
        7: rd_model(12'h01C, "R4 random pending");
        8: rd_model(12'(12'h20C + c*32), "R7/R8 random counter");
        default: rd_model(12'h00C, "R2 random status");
      endcase
    end
    rnd_ticks = 0;
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule